// File: doc/BRIEF.md
# Debug Module Register and Command Unit

This block is the register side of an on-chip debug module. An external debugger reaches it through a simple request/response port: each request carries an opcode (no-op, read, write), a 7-bit register address and a 32-bit write value, and every accepted request is answered one cycle later. The unit holds the control and status words, an abstract-command control/status word, the command word, a set of data words and a program buffer.

Each command the debugger issues turns into one or two one-cycle start pulses toward a hart-side executor. The first pulse is for the register-access phase and the second is for the program-buffer phase. After each pulse the unit waits for a done or fault handshake. While a command is in flight the unit reports busy. It records a sticky error code when the debugger misuses it, when the executor faults, or when the selected hart is not halted. A command can be re-run without rewriting it: reading or writing a data word whose auto-run bit is set launches it again. The debugger selects harts with a contiguous index, and a parameter table translates that index into the hart ID sent to the executor, so the IDs may be sparse.

Top module: `dbg_regunit`

## Requirements
- R1: Every request whose opcode is not no-op (0 = no-op, 1 = read, 2 = write) is accepted at once. The response valid is high in the following cycle. For a read, the response data is the register value as it was before any write in that same cycle.
- R2: While the active bit (control bit 0) is 0, every register other than control reads as 0 and writes to it are dropped. Writing 0 to the active bit clears all state (data words, program buffer, command, error code, auto-run mask, hart select and reset request) and stops any command in flight.
- R3: Control (0x10) holds active at bit 0, the non-debug reset request at bit 1 (driven on `ndm_reset`) and the hart select at bits 16 and up. These fields take a write only while the module is already active. Status (0x11) reads version 3 in bits 3:0, authenticated=1 at bit 7, and at bit 9 whether the selected hart is halted.
- R4: Command word (0x17) bit 0 requests the access phase and bit 1 requests the program-buffer phase. Bit 0 alone gives one start pulse with phase 0. Bits 0 and 1 together give a start with phase 0, then after done a start with phase 1. Bit 1 alone gives one start with phase 1. With neither bit set, no start happens. Each start pulse lasts one cycle.
- R5: `exec_hart_id` equals the table entry for the hart select. The default table maps selects 0, 1, 2, 3 to IDs 0, 3, 7, 12.
- R6: Abstract status (0x16) bit 12 is busy. Busy is 1 from the cycle after a command is accepted until the final done.
- R7: While busy, a command write, a program-buffer write, or any access to a data word with auto-run set sets the error code to 1 if the code was 0. Such writes change no register, and they start nothing.
- R8: The error code sits at bits 10:8 of 0x16. It is sticky and clears only through write-one-to-clear. While it is non-zero, no command starts.
- R9: A fault handshake from the executor ends the command and sets the error code to 3.
- R10: A launch toward a hart that is not halted starts nothing and sets the error code to 4.
- R11: Bits 16 and up of 0x16 form a per-data-word auto-run mask. When idle, a read or write of data word i with mask bit i set re-launches the stored command. Access to a word whose mask bit is clear starts nothing.
- R12: The executor can write data words through its write port and read any data or program-buffer word through its read port. In 0x16, bits 3:0 give the data-word count, bit 13 gives the implicit trailing ebreak flag, and bits 28:24 give the program-buffer size. Data words sit at 0x04 and up; program-buffer words sit at 0x20 and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_op | input | 2 | 0 no-op, 1 read, 2 write |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read value |
| hart_halted | input | NHARTS | Per-hart halted flags |
| dm_active | output | 1 | Module active bit |
| ndm_reset | output | 1 | Non-debug reset request |
| exec_start | output | 1 | One-cycle start toward the executor |
| exec_phase | output | 1 | 0 access phase, 1 program-buffer phase |
| exec_hart_id | output | ID_W | Mapped hart ID |
| exec_cmd | output | 32 | Stored command word |
| exec_done | input | 1 | Phase finished |
| exec_fault | input | 1 | Phase ended with an exception |
| exec_wr_en | input | 1 | Executor data-word write enable |
| exec_wr_idx | input | IDX_W | Executor data-word index |
| exec_wr_data | input | 32 | Executor write value |
| exec_rd_addr | input | 7 | Executor read address |
| exec_rd_data | output | 32 | Executor read value |

## Verification
The bench sweeps every hart select against every command mode. For each case it checks the order of the phase pulses and the mapped ID. A design that dropped the second phase, or sent the raw select instead of the mapped ID, would show a wrong pulse count or a wrong ID. Misuse while busy is tested for the command word, the program buffer and auto-run data words. A design that let such a write through would change the stored value or launch an extra phase. Sticky errors are tested against later launches: a design that still launched would show extra starts. The inactive state is tested by reading registers back after deactivation, which catches state that survives when it should be cleared.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam logic [6:0] A_DATA0 = 7'h04;
  localparam logic [6:0] A_CTRL  = 7'h10;
  localparam logic [6:0] A_STAT  = 7'h11;
  localparam logic [6:0] A_ACS   = 7'h16;
  localparam logic [6:0] A_CMD   = 7'h17;
  localparam logic [6:0] A_PB0   = 7'h20;

  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_BUSY = 3'd1;
  localparam logic [2:0] ERR_EXC  = 3'd3;
  localparam logic [2:0] ERR_HALT = 3'd4;

  typedef enum logic [1:0] {CS_IDLE, CS_LAUNCH, CS_WAIT, CS_FAULT} cmd_st_e;
endpackage

// File: rtl/dbgm_regfile.sv
module dbgm_regfile import dbgm_pkg::*; #(
  parameter int NDATA = 4,
  parameter int NPROG = 4,
  localparam int IDX_W = (NDATA > 1) ? $clog2(NDATA) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dmi_we,
  input  logic [6:0]       dmi_addr,
  input  logic [31:0]      dmi_wdata,
  input  logic             xw_en,
  input  logic [IDX_W-1:0] xw_idx,
  input  logic [31:0]      xw_data,
  input  logic [6:0]       ra_addr,
  output logic [31:0]      ra_data,
  input  logic [6:0]       rb_addr,
  output logic [31:0]      rb_data
);
  logic [31:0] data_q [NDATA];
  logic [31:0] pb_q   [NPROG];

  for (genvar i = 0; i < NDATA; i++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  data_q[i] <= '0;
      else if (clr)                                data_q[i] <= '0;
      else if (xw_en && xw_idx == IDX_W'(i))       data_q[i] <= xw_data;
      else if (dmi_we && dmi_addr == 7'(A_DATA0 + i)) data_q[i] <= dmi_wdata;
    end
  end

  for (genvar j = 0; j < NPROG; j++) begin : g_pb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  pb_q[j] <= '0;
      else if (clr)                                pb_q[j] <= '0;
      else if (dmi_we && dmi_addr == 7'(A_PB0 + j)) pb_q[j] <= dmi_wdata;
    end
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    for (int k = 0; k < NDATA; k++) begin
      if (ra_addr == 7'(A_DATA0 + k)) ra_data = data_q[k];
      if (rb_addr == 7'(A_DATA0 + k)) rb_data = data_q[k];
    end
    for (int k = 0; k < NPROG; k++) begin
      if (ra_addr == 7'(A_PB0 + k)) ra_data = pb_q[k];
      if (rb_addr == 7'(A_PB0 + k)) rb_data = pb_q[k];
    end
  end
endmodule

// File: rtl/dbgm_cmd_fsm.sv
module dbgm_cmd_fsm import dbgm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic launch,
  input  logic want_access,
  input  logic want_prog,
  input  logic exec_done,
  input  logic exec_fault,
  output logic busy,
  output logic exec_start,
  output logic exec_phase,
  output logic fault_evt
);
  cmd_st_e st_q;
  logic    phase_q, prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_IDLE; phase_q <= 1'b0; prog_q <= 1'b0;
    end else if (clr) begin
      st_q <= CS_IDLE; phase_q <= 1'b0; prog_q <= 1'b0;
    end else begin
      case (st_q)
        CS_IDLE: if (launch) begin
          st_q    <= CS_LAUNCH;
          phase_q <= !want_access;
          prog_q  <= want_access && want_prog;
        end
        CS_LAUNCH: st_q <= CS_WAIT;
        CS_WAIT: begin
          if (exec_fault) st_q <= CS_FAULT;
          else if (exec_done) begin
            if (prog_q) begin
              prog_q <= 1'b0; phase_q <= 1'b1; st_q <= CS_LAUNCH;
            end else st_q <= CS_IDLE;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != CS_IDLE);
  assign exec_start = (st_q == CS_LAUNCH);
  assign exec_phase = phase_q;
  assign fault_evt  = (st_q == CS_WAIT) && exec_fault && !clr;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start); // R4
  AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> st_q == CS_IDLE); // R7
endmodule

// File: rtl/dbg_regunit.sv
module dbg_regunit import dbgm_pkg::*; #(
  parameter int NHARTS = 4,
  parameter int ID_W   = 8,
  parameter logic [NHARTS*ID_W-1:0] HART_ID_MAP = {8'd12, 8'd7, 8'd3, 8'd0},
  parameter int NDATA     = 4,
  parameter int NPROG     = 4,
  parameter int IMPEBREAK = 1,
  parameter int VERSION   = 3,
  localparam int HSEL_W = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  localparam int IDX_W  = (NDATA > 1) ? $clog2(NDATA) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NHARTS-1:0] hart_halted,
  output logic              dm_active,
  output logic              ndm_reset,
  output logic              exec_start,
  output logic              exec_phase,
  output logic [ID_W-1:0]   exec_hart_id,
  output logic [31:0]       exec_cmd,
  input  logic              exec_done,
  input  logic              exec_fault,
  input  logic              exec_wr_en,
  input  logic [IDX_W-1:0]  exec_wr_idx,
  input  logic [31:0]       exec_wr_data,
  input  logic [6:0]        exec_rd_addr,
  output logic [31:0]       exec_rd_data
);
  function automatic logic [ID_W-1:0] map_id(input logic [HSEL_W-1:0] s);
    return HART_ID_MAP[int'(s)*ID_W +: ID_W];
  endfunction

  function automatic logic sel_is_halted(input logic [HSEL_W-1:0] s,
                                         input logic [NHARTS-1:0] h);
    logic r = 1'b0;
    for (int k = 0; k < NHARTS; k++) if (int'(s) == k) r = h[k];
    return r;
  endfunction

  function automatic logic [31:0] acs_word(input logic [2:0] e, input logic b,
                                           input logic [NDATA-1:0] am);
    return 32'(NDATA) | (32'(e) << 8) | (32'(b) << 12) | (32'(IMPEBREAK) << 13)
         | (32'(am) << 16) | (32'(NPROG) << 24);
  endfunction

  function automatic logic [31:0] stat_word(input logic hl);
    return (32'(VERSION) & 32'hF) | 32'h80 | (32'(hl) << 9);
  endfunction

  logic              active_q, ndm_q;
  logic [HSEL_W-1:0] hsel_q;
  logic [2:0]        err_q;
  logic [NDATA-1:0]  auto_q;
  logic [31:0]       cmd_q;
  logic              busy, fault_evt;

  // named request events
  logic acc, wr, ctrl_wr, clr, cmd_wr, acs_wr, pb_wr, in_data, auto_hit;
  logic busy_viol, want_launch, launch, halt_fail, sel_halted;
  logic [31:0] cmd_eff, rf_rdata;

  assign req_ready = 1'b1;
  assign acc     = req_valid && (req_op != OP_NOP);
  assign wr      = req_valid && (req_op == OP_WR);
  assign ctrl_wr = wr && (req_addr == A_CTRL);
  assign clr     = !active_q || (ctrl_wr && !req_wdata[0]);
  assign cmd_wr  = wr && active_q && (req_addr == A_CMD);
  assign acs_wr  = wr && active_q && (req_addr == A_ACS);

  always_comb begin
    in_data  = 1'b0;
    auto_hit = 1'b0;
    pb_wr    = 1'b0;
    for (int k = 0; k < NDATA; k++)
      if (req_addr == 7'(A_DATA0 + k)) begin
        in_data  = 1'b1;
        auto_hit = auto_q[k] && acc && active_q;
      end
    for (int k = 0; k < NPROG; k++)
      if (req_addr == 7'(A_PB0 + k)) pb_wr = wr && active_q;
  end

  assign sel_halted  = sel_is_halted(hsel_q, hart_halted);
  assign cmd_eff     = cmd_wr ? req_wdata : cmd_q;
  assign busy_viol   = busy && (cmd_wr || pb_wr || auto_hit);
  assign want_launch = !busy && (cmd_wr || auto_hit) && (err_q == ERR_NONE)
                       && (cmd_eff[1:0] != 2'b00);
  assign launch      = want_launch && sel_halted && !clr;
  assign halt_fail   = want_launch && !sel_halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; ndm_q <= 1'b0; hsel_q <= '0;
    end else if (ctrl_wr) begin
      active_q <= req_wdata[0];
      ndm_q    <= active_q && req_wdata[0] && req_wdata[1];
      hsel_q   <= (active_q && req_wdata[0]) ? req_wdata[16 +: HSEL_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= ERR_NONE; auto_q <= '0; cmd_q <= '0;
    end else if (clr) begin
      err_q <= ERR_NONE; auto_q <= '0; cmd_q <= '0;
    end else begin
      if (cmd_wr && !busy) cmd_q <= req_wdata;
      if (acs_wr) auto_q <= req_wdata[16 +: NDATA];
      if (busy_viol) begin
        if (err_q == ERR_NONE) err_q <= ERR_BUSY;
      end else if (halt_fail) err_q <= ERR_HALT;
      else if (fault_evt) begin
        if (err_q == ERR_NONE) err_q <= ERR_EXC;
      end else if (acs_wr) err_q <= err_q & ~req_wdata[10:8];
    end
  end

  dbgm_regfile #(.NDATA(NDATA), .NPROG(NPROG)) u_rf (
    .clk, .rst_n, .clr,
    .dmi_we(wr && !busy && !clr), .dmi_addr(req_addr), .dmi_wdata(req_wdata),
    .xw_en(exec_wr_en && !clr), .xw_idx(exec_wr_idx), .xw_data(exec_wr_data),
    .ra_addr(req_addr), .ra_data(rf_rdata),
    .rb_addr(exec_rd_addr), .rb_data(exec_rd_data)
  );

  dbgm_cmd_fsm u_fsm (
    .clk, .rst_n, .clr, .launch,
    .want_access(cmd_eff[0]), .want_prog(cmd_eff[1]),
    .exec_done, .exec_fault, .busy, .exec_start, .exec_phase, .fault_evt
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      if (acc && req_op == OP_RD) begin
        if (!active_q) rsp_rdata <= '0;
        else case (req_addr)
          A_CTRL:  rsp_rdata <= {{(16-HSEL_W){1'b0}}, hsel_q, 14'd0, ndm_q, active_q};
          A_STAT:  rsp_rdata <= stat_word(sel_halted);
          A_ACS:   rsp_rdata <= acs_word(err_q, busy, auto_q);
          A_CMD:   rsp_rdata <= cmd_q;
          default: rsp_rdata <= rf_rdata;
        endcase
      end
    end
  end

  assign dm_active    = active_q;
  assign ndm_reset    = ndm_q;
  assign exec_hart_id = map_id(hsel_q);
  assign exec_cmd     = cmd_q;

  AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !busy); // R2
  AST_VIOL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_viol |=> err_q != ERR_NONE); // R7
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(err_q) == ERR_NONE) && $past(sel_halted)); // R8
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && err_q == ERR_NONE && !busy_viol) |=> err_q == ERR_EXC); // R9
  AST_NO_WRITE_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q)); // R7
endmodule

// File: tb/dbg_regunit_tb.sv
module dbg_regunit_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid;
  logic [1:0] req_op = 0;
  logic [6:0] req_addr = 0, exec_rd_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata, exec_cmd, exec_wr_data = 0, exec_rd_data;
  logic [3:0] hart_halted = 4'b1111;
  logic dm_active, ndm_reset, exec_start, exec_phase;
  logic exec_done = 0, exec_fault = 0, exec_wr_en = 0;
  logic [1:0] exec_wr_idx = 0;
  logic [7:0] exec_hart_id;

  int total = 0, bad = 0, n_starts = 0, resp_delay = 3;
  bit resp_fault = 0, finished = 0;
  bit ph_log [8];
  logic [7:0] id_log [8];
  logic [31:0] r;
  logic rv;

  always #2 clk = ~clk;

  dbg_regunit u_dut (.*);

  function automatic logic [7:0] exp_id(int s);
    logic [7:0] t [4] = '{8'd0, 8'd3, 8'd7, 8'd12};
    return t[s];
  endfunction
  function automatic logic [31:0] exp_acs(int e, int b, int am);
    return 4 + e * 256 + b * 4096 + 8192 + am * 65536 + 4 * 16777216;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dmi(input logic [1:0] op, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_op = 0;
    r = rsp_rdata; rv = rsp_valid;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  // executor model
  initial begin
    @(negedge clk);
    forever begin
      if (exec_start === 1'b1) begin
        ph_log[n_starts % 8] = exec_phase;
        id_log[n_starts % 8] = exec_hart_id;
        n_starts++;
        repeat (resp_delay) @(negedge clk);
        if (resp_fault) exec_fault = 1;
        else begin
          exec_done = 1;
          if (!exec_phase) begin
            exec_wr_en = 1; exec_wr_idx = 0; exec_wr_data = exec_cmd ^ 32'hA5A5_0000;
          end
        end
        @(negedge clk);
        exec_done = 0; exec_fault = 0; exec_wr_en = 0;
      end else @(negedge clk);
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    logic [31:0] c;
    repeat (4) @(negedge clk);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 0);
    rst_n = 1;
    dmi(1, 7'h10, 0); chk("R1 rsp_valid after read", {31'd0, rv}, 1);
    chk("R2 ctrl inactive", r, 0);
    dmi(1, 7'h11, 0); chk("R2 status inactive", r, 0);
    dmi(2, 7'h04, 32'h1234);
    dmi(2, 7'h10, 1);
    dmi(1, 7'h04, 0); chk("R2 inactive write dropped", r, 0);

    // R3 status sweep
    hart_halted = 4'b0101;
    for (int s = 0; s < 4; s++) begin
      dmi(2, 7'h10, 1 + (s << 16));
      dmi(1, 7'h10, 0); chk("R3 ctrl readback", r, 1 + (s << 16));
      dmi(1, 7'h11, 0); chk("R3 status", r, 3 + 128 + (((4'b0101 >> s) & 1) << 9));
    end
    hart_halted = 4'b1111;

    // R4 R5 R6 sweep
    for (int s = 0; s < 4; s++) begin
      for (int m = 1; m < 4; m++) begin
        dmi(2, 7'h10, 1 + (s << 16));
        n0 = n_starts;
        c = m + (s << 8) + 32'h0010_0000;
        dmi(2, 7'h17, c);
        dmi(1, 7'h16, 0); chk("R6 busy during command", r, exp_acs(0, 1, 0));
        settle();
        chk("R4 start count", n_starts - n0, (m == 3) ? 2 : 1);
        chk("R4 first phase", {31'd0, ph_log[n0 % 8]}, (m == 2) ? 1 : 0);
        if (m == 3) chk("R4 second phase", {31'd0, ph_log[(n0 + 1) % 8]}, 1);
        chk("R5 mapped id", {24'd0, id_log[n0 % 8]}, {24'd0, exp_id(s)});
        if (m != 2) begin
          dmi(1, 7'h04, 0); chk("R12 executor result", r, c ^ 32'hA5A5_0000);
        end
        dmi(1, 7'h16, 0); chk("R6 idle after done", r, exp_acs(0, 0, 0));
      end
    end
    dmi(2, 7'h10, 1);
    n0 = n_starts;
    dmi(2, 7'h17, 32'h100); settle();
    chk("R4 no mode bits no start", n_starts - n0, 0);

    // R7 busy violations
    resp_delay = 10;
    n0 = n_starts;
    dmi(2, 7'h17, 32'hAA01);
    dmi(2, 7'h17, 32'hBB03);
    dmi(1, 7'h16, 0); chk("R7 busy error code", r, exp_acs(1, 1, 0));
    settle();
    dmi(1, 7'h17, 0); chk("R7 command unchanged", r, 32'hAA01);
    chk("R7 one start only", n_starts - n0, 1);
    dmi(2, 7'h16, 32'h700);
    dmi(1, 7'h16, 0); chk("R8 write-one-to-clear", r, exp_acs(0, 0, 0));
    dmi(2, 7'h17, 32'h1);
    dmi(2, 7'h21, 32'hDEAD);
    settle();
    dmi(1, 7'h21, 0); chk("R7 progbuf write dropped", r, 0);
    dmi(1, 7'h16, 0); chk("R7 progbuf busy error", r, exp_acs(1, 0, 0));
    n0 = n_starts;
    dmi(2, 7'h17, 32'h1); settle();
    chk("R8 error blocks start", n_starts - n0, 0);
    dmi(1, 7'h16, 0); chk("R8 error sticky", r, exp_acs(1, 0, 0));
    dmi(2, 7'h16, 32'h100);
    resp_delay = 3;

    // R9 fault
    resp_fault = 1;
    dmi(2, 7'h17, 32'h1); settle();
    dmi(1, 7'h16, 0); chk("R9 exception code", r, exp_acs(3, 0, 0));
    resp_fault = 0;
    dmi(2, 7'h16, 32'h700);

    // R10 not halted
    hart_halted = 4'b1011;
    dmi(2, 7'h10, 1 + (2 << 16));
    n0 = n_starts;
    dmi(2, 7'h17, 32'h1); settle();
    chk("R10 no start", n_starts - n0, 0);
    dmi(1, 7'h16, 0); chk("R10 halt code", r, exp_acs(4, 0, 0));
    dmi(2, 7'h16, 32'h700);
    hart_halted = 4'b1111;
    dmi(2, 7'h10, 1);

    // R11 auto-run
    dmi(2, 7'h16, 32'h2 << 16);
    dmi(1, 7'h16, 0); chk("R11 mask readback", r, exp_acs(0, 0, 2));
    dmi(2, 7'h17, 32'h1); settle();
    n0 = n_starts;
    dmi(1, 7'h05, 0); settle();
    chk("R11 read re-runs", n_starts - n0, 1);
    dmi(1, 7'h04, 0); settle();
    chk("R11 unmasked no run", n_starts - n0, 1);
    dmi(2, 7'h05, 32'h55); settle();
    chk("R11 write re-runs", n_starts - n0, 2);
    dmi(1, 7'h05, 0); chk("R11 data written", r, 32'h55);
    settle();
    resp_delay = 10;
    dmi(2, 7'h17, 32'h1);
    dmi(2, 7'h05, 32'h77);
    dmi(1, 7'h16, 0); chk("R7 auto-run while busy", r, exp_acs(1, 1, 2));
    settle();
    dmi(2, 7'h16, 32'h700);
    dmi(1, 7'h05, 0); settle();
    chk("R7 data unchanged", r, 32'h55);
    resp_delay = 3;
    dmi(2, 7'h16, 0);

    // R12 executor read port
    dmi(2, 7'h22, 32'hCAFE_0002);
    exec_rd_addr = 7'h22; @(negedge clk);
    chk("R12 progbuf read port", exec_rd_data, 32'hCAFE_0002);
    exec_rd_addr = 7'h05; @(negedge clk);
    chk("R12 data read port", exec_rd_data, 32'h55);

    // R3 reset request, R2 deactivate
    dmi(2, 7'h10, 3);
    chk("R3 ndm_reset", {31'd0, ndm_reset}, 1);
    dmi(2, 7'h16, 32'h1 << 16);
    dmi(2, 7'h10, 0);
    dmi(1, 7'h16, 0); chk("R2 acs inactive", r, 0);
    chk("R2 ndm_reset cleared", {31'd0, ndm_reset}, 0);
    dmi(2, 7'h10, 1);
    dmi(1, 7'h05, 0); chk("R2 data cleared", r, 0);
    dmi(1, 7'h22, 0); chk("R2 progbuf cleared", r, 0);
    dmi(1, 7'h16, 0); chk("R2 acs cleared", r, exp_acs(0, 0, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule